// File: doc/BRIEF.md
# Single-Channel DMA Transfer Sequencer

This block runs the transfers of one DMA channel in single-transfer mode. The register file supplies the mode byte, a mask control, a base address and a transfer count. The block keeps the working 16-bit address and count. Each request that is accepted produces exactly one bus cycle, with one acknowledge pulse. The cycle is a memory write or a memory read, as the mode selects. After each cycle the address steps up by one and the count steps down by one.

The count holds the number of transfers minus one. A load of zero therefore gives one transfer, and the last transfer is the one that takes the count from 0x0000 to 0xFFFF. That transfer raises terminal count. If autoinit is set, the channel then reloads its base values and stays live. If autoinit is clear, the channel masks itself.

In word mode the register address counts 16-bit words. The external byte address is the register address shifted up by one bit, and the page then selects a 128K region. In cascade mode the block generates no addresses. It only relays the request to the hold request output and the hold acknowledge back to the channel acknowledge.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset the channel is masked (mask_o=1), cur_addr_o and cur_count_o are 0, and dack_o, mem_wr_o, mem_rd_o, tc_o and hold_req_o are all low.
- R2: A clock edge with cfg_load_i high writes cfg_addr_i and cfg_count_i into both the base copies and the working address and count.
- R3: While mask_o is 1 a request starts no cycle. mask_set_i sets the mask and mask_clr_i clears it, and set wins when both are high.
- R4: In single-transfer mode (mode_i[7:6] not 2'b11), dreq_i seen high at an edge while the channel is idle and unmasked starts a bus cycle that lasts exactly one clock. The channel is idle for at least one clock between cycles, and dreq_i must be seen high again before the next cycle starts.
- R5: mode_i[3:2]=2'b01 (for example mode 0x44) drives mem_wr_o during the cycle. mode_i[3:2]=2'b10 (for example mode 0x48) drives mem_rd_o. Any other value drives neither.
- R6: Each completed cycle adds 1 to the working address modulo 65536 and takes 1 from the working count modulo 65536. The page value is never changed.
- R7: tc_o is high, together with dack_o, during the cycle whose starting count is 0x0000. A count loaded as 0 gives exactly one transfer.
- R8: With the autoinit bit mode_i[4] clear, terminal count sets mask_o and leaves the count at 0xFFFF.
- R9: With mode_i[4] set, terminal count reloads the working address and count from the base copies and leaves the mask clear.
- R10: With word_mode_i=0, ext_addr_o = {page_i, address}. With word_mode_i=1, ext_addr_o = {page_i[7:1], address, 1'b0}.
- R11: In cascade mode (mode_i[7:6]=2'b11), hold_req_o = dreq_i and dack_o = hold_ack_i while unmasked, and both are 0 while masked. No strobe is driven and the address and count do not change.
- R12: A load on the edge that ends a cycle takes priority over that cycle's address and count step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load_i | input | 1 | Load base and working address/count |
| cfg_addr_i | input | 16 | Start address (bytes, or words in word mode) |
| cfg_count_i | input | 16 | Transfers minus one |
| mode_i | input | 8 | Mode byte: [7:6] service type, [4] autoinit, [3:2] direction |
| word_mode_i | input | 1 | 1 = 16-bit transfers with a shifted address |
| page_i | input | 8 | Page bits above the 16-bit address |
| mask_set_i | input | 1 | Set the channel mask |
| mask_clr_i | input | 1 | Clear the channel mask |
| dreq_i | input | 1 | Device request |
| hold_ack_i | input | 1 | Hold acknowledge (used in cascade mode) |
| dack_o | output | 1 | Channel acknowledge |
| hold_req_o | output | 1 | Hold request (used in cascade mode) |
| mem_wr_o | output | 1 | Memory write strobe for the current cycle |
| mem_rd_o | output | 1 | Memory read strobe for the current cycle |
| tc_o | output | 1 | Terminal count, high during the last cycle |
| ext_addr_o | output | 24 | External byte address |
| cur_addr_o | output | 16 | Working address |
| cur_count_o | output | 16 | Working count |
| mask_o | output | 1 | Channel mask state |

## Verification
A wrong working count shows up on cur_count_o in the clock after the bad step. It also moves tc_o, and so the masking or the reload, to the wrong transfer within that run. A wrong working address shows on cur_addr_o and, in the next cycle, on ext_addr_o. A wrong mask or sequencer state shows as a missing, extra or two-clock acknowledge within one or two clocks of the request. The bench's reference model compares every output on every clock, so each of these faults is reported in the cycle where it first reaches the ports.

// File: rtl/dma_seq_pkg.sv
`timescale 1ns/1ps
package dma_seq_pkg;

    localparam int ADDR_W = 16;
    localparam int CNT_W  = 16;
    localparam int PAGE_W = 8;
    localparam int EXT_W  = ADDR_W + PAGE_W;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_XFER = 1'b1
    } seq_state_e;

    typedef enum logic [1:0] {
        DIR_VERIFY = 2'b00,
        DIR_MEMWR  = 2'b01,
        DIR_MEMRD  = 2'b10,
        DIR_NONE   = 2'b11
    } xfer_dir_e;

    typedef struct packed {
        logic      cascade;
        logic      autoinit;
        xfer_dir_e dir;
    } mode_cfg_t;

    typedef struct packed {
        seq_state_e         state;
        logic [ADDR_W-1:0]  base_addr;
        logic [CNT_W-1:0]   base_cnt;
        logic [ADDR_W-1:0]  cur_addr;
        logic [CNT_W-1:0]   cur_cnt;
        logic               mask;
    } chan_regs_t;

endpackage

// File: rtl/dma_mode_decode.sv
`timescale 1ns/1ps
module dma_mode_decode
    import dma_seq_pkg::*;
(
    input  logic [1:0] svc_bits_i,
    input  logic       auto_bit_i,
    input  logic [1:0] dir_bits_i,
    output mode_cfg_t  cfg_o
);
    always_comb begin
        cfg_o.cascade  = (svc_bits_i == 2'b11);
        cfg_o.autoinit = auto_bit_i;
        cfg_o.dir      = xfer_dir_e'(dir_bits_i);
    end
endmodule

// File: rtl/dma_count_step.sv
`timescale 1ns/1ps
module dma_count_step #(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic [AW-1:0] addr_i,
    input  logic [CW-1:0] cnt_i,
    output logic [AW-1:0] addr_next_o,
    output logic [CW-1:0] cnt_next_o,
    output logic          last_o
);
    localparam logic [AW-1:0] ADDR_ONE = AW'(1);
    localparam logic [CW-1:0] CNT_ONE  = CW'(1);

    always_comb begin
        addr_next_o = addr_i + ADDR_ONE;
        cnt_next_o  = cnt_i - CNT_ONE;
        last_o      = (cnt_i == '0);
    end
endmodule

// File: rtl/dma_ext_addr.sv
`timescale 1ns/1ps
module dma_ext_addr #(
    parameter int AW = 16,
    parameter int PW = 8
) (
    input  logic             word_mode_i,
    input  logic [PW-1:0]    page_i,
    input  logic [AW-1:0]    addr_i,
    output logic [AW+PW-1:0] ext_o
);
    logic [AW+PW-1:0] byte_form;
    logic [AW+PW-1:0] word_form;

    always_comb begin
        byte_form = {page_i, addr_i};
        word_form = {page_i[PW-1:1], addr_i, 1'b0};
        ext_o     = word_mode_i ? word_form : byte_form;
    end
endmodule

// File: rtl/dma_chan_seq.sv
`timescale 1ns/1ps
module dma_chan_seq
    import dma_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load_i,
    input  logic [ADDR_W-1:0] cfg_addr_i,
    input  logic [CNT_W-1:0]  cfg_count_i,
    input  logic [7:0]        mode_i,
    input  logic              word_mode_i,
    input  logic [PAGE_W-1:0] page_i,
    input  logic              mask_set_i,
    input  logic              mask_clr_i,
    input  logic              dreq_i,
    input  logic              hold_ack_i,
    output logic              dack_o,
    output logic              hold_req_o,
    output logic              mem_wr_o,
    output logic              mem_rd_o,
    output logic              tc_o,
    output logic [EXT_W-1:0]  ext_addr_o,
    output logic [ADDR_W-1:0] cur_addr_o,
    output logic [CNT_W-1:0]  cur_count_o,
    output logic              mask_o
);

    chan_regs_t        regs_d, regs_q;
    mode_cfg_t         mode_cfg;
    logic [ADDR_W-1:0] addr_step;
    logic [CNT_W-1:0]  cnt_step;
    logic              last_xfer;
    logic              in_xfer;
    logic              tc_mask_d;
    logic              unused_mode_bits;

    assign unused_mode_bits = ^{mode_i[5], mode_i[1:0]};

    dma_mode_decode u_mode (
        .svc_bits_i (mode_i[7:6]),
        .auto_bit_i (mode_i[4]),
        .dir_bits_i (mode_i[3:2]),
        .cfg_o      (mode_cfg)
    );

    dma_count_step #(.AW(ADDR_W), .CW(CNT_W)) u_step (
        .addr_i      (regs_q.cur_addr),
        .cnt_i       (regs_q.cur_cnt),
        .addr_next_o (addr_step),
        .cnt_next_o  (cnt_step),
        .last_o      (last_xfer)
    );

    dma_ext_addr #(.AW(ADDR_W), .PW(PAGE_W)) u_ext (
        .word_mode_i (word_mode_i),
        .page_i      (page_i),
        .addr_i      (regs_q.cur_addr),
        .ext_o       (ext_addr_o)
    );

    assign in_xfer = (regs_q.state == SEQ_XFER);

    always_comb begin
        regs_d    = regs_q;
        tc_mask_d = 1'b0;

        if (in_xfer) begin
            if (!last_xfer) begin
                regs_d.cur_addr = addr_step;
                regs_d.cur_cnt  = cnt_step;
            end else if (mode_cfg.autoinit) begin
                regs_d.cur_addr = regs_q.base_addr;
                regs_d.cur_cnt  = regs_q.base_cnt;
            end else begin
                regs_d.cur_addr = addr_step;
                regs_d.cur_cnt  = cnt_step;
                tc_mask_d       = 1'b1;
            end
            regs_d.state = SEQ_IDLE;
        end else if (!regs_q.mask && dreq_i && !mode_cfg.cascade) begin
            regs_d.state = SEQ_XFER;
        end

        if (cfg_load_i) begin
            regs_d.base_addr = cfg_addr_i;
            regs_d.base_cnt  = cfg_count_i;
            regs_d.cur_addr  = cfg_addr_i;
            regs_d.cur_cnt   = cfg_count_i;
        end

        if (mask_set_i || tc_mask_d) begin
            regs_d.mask = 1'b1;
        end else if (mask_clr_i) begin
            regs_d.mask = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '{state: SEQ_IDLE, base_addr: '0, base_cnt: '0,
                        cur_addr: '0, cur_cnt: '0, mask: 1'b1};
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        hold_req_o = mode_cfg.cascade && !regs_q.mask && dreq_i;
        dack_o     = in_xfer || (mode_cfg.cascade && !regs_q.mask && hold_ack_i);
        mem_wr_o   = in_xfer && (mode_cfg.dir == DIR_MEMWR);
        mem_rd_o   = in_xfer && (mode_cfg.dir == DIR_MEMRD);
        tc_o       = in_xfer && last_xfer;
    end

    assign cur_addr_o  = regs_q.cur_addr;
    assign cur_count_o = regs_q.cur_cnt;
    assign mask_o      = regs_q.mask;

    // R4: a strobe lasts one clock and is followed by an idle clock
    a_r4_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_o || mem_rd_o) |=> !(mem_wr_o || mem_rd_o));

    // R3: an idle masked channel does not begin a cycle
    a_r3_masked_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_o && !tc_o && !dack_o) |=> !(mem_wr_o || mem_rd_o || tc_o));

    // R6: a non-final strobed cycle steps the address by one
    a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_wr_o || mem_rd_o) && !tc_o && !cfg_load_i)
        |=> (cur_addr_o == $past(cur_addr_o) + 16'd1));

    // R8: terminal count without autoinit masks and leaves all ones
    a_r8_tc_masks: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_o && !mode_i[4] && !cfg_load_i)
        |=> (mask_o && cur_count_o == 16'hFFFF));

    // R9: terminal count with autoinit keeps the channel live
    a_r9_tc_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_o && mode_i[4] && !mask_set_i) |=> !mask_o);

    // R11: cascade service never strobes memory
    a_r11_cascade_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i[7:6] == 2'b11 && !dack_o && !cfg_load_i)
        |=> (mode_i[7:6] != 2'b11) || (!mem_wr_o && !mem_rd_o));

endmodule

// File: tb/dma_chan_seq_bench.sv
`timescale 1ns/1ps
module dma_chan_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_load = 1'b0;
    logic [15:0] cfg_addr = '0;
    logic [15:0] cfg_count = '0;
    logic [7:0]  mode = 8'h44;
    logic        word_mode = 1'b0;
    logic [7:0]  page = '0;
    logic        mask_set = 1'b0;
    logic        mask_clr = 1'b0;
    logic        dreq = 1'b0;
    logic        hold_ack = 1'b0;
    logic        dack, hold_req, mem_wr, mem_rd, tc, mask;
    logic [23:0] ext_addr;
    logic [15:0] cur_addr, cur_count;

    int n_chk = 0;
    int n_err = 0;
    int n_dack = 0;
    bit done = 1'b0;

    // reference model state
    bit          m_x;
    logic [15:0] m_addr, m_cnt, m_ba, m_bc;
    bit          m_mask;

    always #2.5 clk = ~clk;

    dma_chan_seq u_dma_chan_seq (
        .clk(clk), .rst_n(rst_n), .cfg_load_i(cfg_load), .cfg_addr_i(cfg_addr),
        .cfg_count_i(cfg_count), .mode_i(mode), .word_mode_i(word_mode),
        .page_i(page), .mask_set_i(mask_set), .mask_clr_i(mask_clr),
        .dreq_i(dreq), .hold_ack_i(hold_ack), .dack_o(dack),
        .hold_req_o(hold_req), .mem_wr_o(mem_wr), .mem_rd_o(mem_rd),
        .tc_o(tc), .ext_addr_o(ext_addr), .cur_addr_o(cur_addr),
        .cur_count_o(cur_count), .mask_o(mask)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    // behavioural reference model, advanced on every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_x = 0; m_addr = 0; m_cnt = 0; m_ba = 0; m_bc = 0; m_mask = 1;
        end else begin
            bit casc, setm;
            casc = (mode[7:6] == 2'b11);
            setm = mask_set;
            if (m_x) begin
                if (m_cnt == 16'd0) begin
                    if (mode[4]) begin
                        m_addr = m_ba; m_cnt = m_bc;
                    end else begin
                        m_addr = m_addr + 16'd1; m_cnt = 16'hFFFF; setm = 1;
                    end
                end else begin
                    m_addr = m_addr + 16'd1; m_cnt = m_cnt - 16'd1;
                end
                m_x = 0;
            end else if (!m_mask && dreq && !casc) begin
                m_x = 1;
            end
            if (cfg_load) begin
                m_ba = cfg_addr; m_bc = cfg_count; m_addr = cfg_addr; m_cnt = cfg_count;
            end
            if (setm) m_mask = 1;
            else if (mask_clr) m_mask = 0;
        end
    end

    // compare every output on every falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit casc;
            logic [23:0] ex;
            casc = (mode[7:6] == 2'b11);
            if (word_mode) ex = (24'(page >> 1) << 17) | (24'(m_addr) << 1);
            else ex = (24'(page) << 16) | 24'(m_addr);
            if (dack) n_dack++;
            chk("R4 dack", dack, m_x ? 1 : (casc && !m_mask && hold_ack));
            chk("R11 hold_req", hold_req, casc && !m_mask && dreq);
            chk("R5 mem_wr", mem_wr, m_x && mode[3:2] == 2'b01);
            chk("R5 mem_rd", mem_rd, m_x && mode[3:2] == 2'b10);
            chk("R7 tc", tc, m_x && m_cnt == 16'd0);
            chk("R6 cur_addr", cur_addr, m_addr);
            chk("R6 cur_count", cur_count, m_cnt);
            chk("R3 mask", mask, m_mask);
            if (m_x) chk("R10 ext_addr", ext_addr, ex);
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=running expected=finished");
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst_n = 1;
        step();
        // R1 reset state
        chk("R1 mask", mask, 1);
        chk("R1 addr", cur_addr, 0);
        chk("R1 count", cur_count, 0);
        chk("R1 strobes", {dack, mem_wr, mem_rd, tc, hold_req}, 0);

        // R2 load
        cfg_load = 1; cfg_addr = 16'h1234; cfg_count = 16'd2; mode = 8'h44; page = 8'h05;
        step();
        cfg_load = 0;
        step();
        chk("R2 addr", cur_addr, 16'h1234);
        chk("R2 count", cur_count, 16'd2);

        // R3 masked channel ignores request
        dreq = 1; n_dack = 0;
        repeat (6) step();
        chk("R3 no dack", n_dack, 0);
        chk("R3 addr held", cur_addr, 16'h1234);

        // R4 R5 R8 three byte transfers then self-mask
        mask_clr = 1;
        step();
        mask_clr = 0; n_dack = 0;
        repeat (10) step();
        dreq = 0;
        chk("R4 dack count", n_dack, 3);
        chk("R8 mask", mask, 1);
        chk("R8 count", cur_count, 16'hFFFF);
        chk("R6 addr", cur_addr, 16'h1237);

        // R9 R10 R6 word mode autoinit with address wrap
        mode = 8'h58; word_mode = 1; page = 8'h07;
        cfg_load = 1; cfg_addr = 16'hFFFE; cfg_count = 16'd3; mask_clr = 1;
        step();
        cfg_load = 0; mask_clr = 0; dreq = 1; n_dack = 0;
        repeat (16) step();
        dreq = 0;
        step();
        chk("R9 dack count", n_dack, 8);
        chk("R9 mask clear", mask, 0);
        chk("R9 addr reload", cur_addr, 16'hFFFE);
        chk("R9 count reload", cur_count, 16'd3);

        // R11 cascade pass-through
        mode = 8'hC0; word_mode = 0; dreq = 1; hold_ack = 0;
        step();
        chk("R11 hold_req", hold_req, 1);
        chk("R11 dack low", dack, 0);
        hold_ack = 1;
        step();
        chk("R11 dack", dack, 1);
        chk("R11 no strobe", {mem_wr, mem_rd}, 0);
        mask_set = 1;
        step();
        mask_set = 0;
        step();
        chk("R11 masked", {hold_req, dack}, 0);
        chk("R11 addr held", cur_addr, 16'hFFFE);
        dreq = 0; hold_ack = 0;

        // R12 load during a cycle wins
        mode = 8'h44; mask_clr = 1; cfg_load = 1; cfg_addr = 16'h0100; cfg_count = 16'd5;
        step();
        mask_clr = 0; cfg_load = 0; dreq = 1;
        step();
        chk("R12 in cycle", mem_wr, 1);
        dreq = 0; cfg_load = 1; cfg_addr = 16'h0200; cfg_count = 16'd9;
        step();
        cfg_load = 0;
        chk("R12 addr", cur_addr, 16'h0200);
        chk("R12 count", cur_count, 16'd9);

        // R7 count of zero gives one transfer
        mode = 8'h48; cfg_load = 1; cfg_addr = 16'h0010; cfg_count = 16'd0; mask_clr = 1;
        step();
        cfg_load = 0; mask_clr = 0; dreq = 1;
        step();
        chk("R7 tc", tc, 1);
        chk("R5 mem_rd", mem_rd, 1);
        dreq = 0;
        step();
        chk("R7 count", cur_count, 16'hFFFF);
        chk("R8 masked", mask, 1);

        repeat (3) step();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule